// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control core of one thread's rename stage in an out-of-order pipeline. Each cycle, decode presents a bundle of up to `W` instructions. Each instruction carries a tag, a serialize-before flag, a serialize-after flag and a kill flag. The kill flag marks an instruction that decode has already squashed.

When the stage can proceed, the block passes the surviving instructions downstream in order. When it cannot proceed, it parks them in an internal skid buffer. It tells decode to hold off with a one-cycle block pulse, and it lets decode resume with a one-cycle unblock pulse.

Register mapping and resource accounting live in neighbouring blocks. This controller only sees two things from them: how many instructions may be renamed this cycle, and whether the physical register pool is empty. From the later stages it receives a squash request, a "still squashing" level and a stall level. It also receives a level saying the reorder buffer is empty with nothing in flight. Instructions that must run alone wait for that level before they go on.

Top module: `rn_stage`

## Requirements
- R1: After reset the state output reads Idle (code 0), the skid buffer is empty, and no instruction, block pulse or unblock pulse is produced. State codes are Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4 and SerialWait 5.
- R2: In Idle or Running, the decode slots below `dec_cnt` are renamed in slot order, up to min(`can_rename`, W) per cycle. A slot with its kill bit set is dropped and uses no output position. Output position i carries its tag in `ren_tags[i*TAG_W +: TAG_W]`.
- R3: The skid buffer holds 2·FB_DELAY·W + W entries. `skid_ovf` never rises while decode honours the block/unblock handshake.
- R4: Suppose renaming cannot finish in Idle or Running, because of a rename limit, an empty register pool or `stall_in`. The leftover instructions then go to the skid buffer, `blk_pulse` is high for that one cycle, and the next state is Blocked. No block pulse is ever produced from Blocked or Unblocking, and the two pulses are never high together.
- R5: Blocked moves to Unblocking on the cycle after `stall_in` is seen low. Unblocking renames from the skid buffer head under the same rules as R2. Any decode input that arrives meanwhile is appended behind the buffered entries.
- R6: In the Unblocking cycle that leaves the skid buffer empty, `unblk_pulse` is high and the next state is Running.
- R7: `squash_in` overrides every other input. It discards the skid buffer, the current input, any held serializing instruction and the serialize-after mark, and the next state is Squashing. `unblk_pulse` is high in that cycle exactly when the state was Blocked, Unblocking or SerialWait.
- R8: Squashing persists while `squashing_in` is high and otherwise becomes Running the next cycle. Decode input offered during Squashing is never renamed.
- R9: An instruction marked serialize-before stops renaming, is held, and the next state is SerialWait, with a block pulse when entered from Idle or Running. Once `rob_drained` is high and `stall_in` low, it is placed at the head of the skid buffer and the state becomes Unblocking. It is then renamed exactly once, without stalling again.
- R10: SerialWait never moves to Blocked. Without a squash, its only successors are itself and Unblocking.
- R11: A renamed serialize-after instruction makes the next instruction serialize-before, even one arriving in a later cycle. This pending mark is dropped if `rob_drained` is high when the next rename attempt begins.
- R12: Every tag that decode offers with its kill bit clear, outside Squashing and outside a squash cycle, is renamed exactly once and in offer order, unless a later squash discards it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_cnt | input | CW | Number of occupied decode slots |
| dec_tags | input | W*TAG_W | Tag per decode slot |
| dec_sb | input | W | Serialize-before flag per slot |
| dec_sa | input | W | Serialize-after flag per slot |
| dec_kill | input | W | Slot already squashed by decode |
| can_rename | input | CW | Instructions the resource logic admits this cycle |
| regs_empty | input | 1 | No free physical register |
| rob_drained | input | 1 | Reorder buffer empty and nothing in flight |
| stall_in | input | 1 | Stall from a later stage |
| squash_in | input | 1 | Squash request from commit |
| squashing_in | input | 1 | Later stage still squashing |
| ren_cnt | output | CW | Instructions renamed this cycle |
| ren_tags | output | W*TAG_W | Tags of renamed instructions, position 0 first |
| blk_pulse | output | 1 | One-cycle request for decode to hold |
| unblk_pulse | output | 1 | One-cycle release for decode |
| state_o | output | 3 | Current control state |
| skid_ovf | output | 1 | Skid buffer would exceed its capacity |

## Verification
A corrupted skid pointer or a wrong pop count shows up at `ren_tags` within a few cycles of an unblock. It appears as a skipped, repeated or reordered tag, so the bench compares every renamed tag against the order in which decode offered it. A wrong state transition shows one cycle later, on `state_o` or as a missing or extra handshake pulse. A held serializing instruction that is lost or renamed twice shows up as a tag error once SerialWait is left.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_BLOCKED = 3'd2,
    ST_UNBLOCK = 3'd3,
    ST_SQUASH  = 3'd4,
    ST_SERIAL  = 3'd5
  } rn_state_e;

  // entry layout: {tag, sb, sa, handled}
  localparam int FL_HD  = 0;
  localparam int FL_SA  = 1;
  localparam int FL_SB  = 2;
  localparam int FLAG_W = 3;

  function automatic int skid_cap(int fb_delay, int width);
    return 2 * fb_delay * width + width;
  endfunction

  function automatic int min_int(int a, int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/rn_compact.sv
module rn_compact #(
  parameter int W     = 2,
  parameter int TAG_W = 8,
  parameter int CW    = 2,
  parameter int EW    = TAG_W + rn_pkg::FLAG_W
) (
  input  logic [CW-1:0]      cnt,
  input  logic [W*TAG_W-1:0] tags,
  input  logic [W-1:0]       sb,
  input  logic [W-1:0]       sa,
  input  logic [W-1:0]       kill,
  output logic [EW-1:0]      ent [W],
  output logic [CW-1:0]      n
);
  always_comb begin
    automatic int k = 0;
    for (int i = 0; i < W; i++) ent[i] = '0;
    for (int i = 0; i < W; i++) begin
      if (i < int'(cnt) && !kill[i]) begin
        ent[k] = {tags[i*TAG_W +: TAG_W], sb[i], sa[i], 1'b0};
        k++;
      end
    end
    n = CW'(k);
  end
endmodule

// File: rtl/rn_scan.sv
module rn_scan #(
  parameter int W  = 2,
  parameter int CW = 2,
  parameter int EW = 11
) (
  input  logic [EW-1:0] src [W],
  input  logic [CW-1:0] avail,
  input  logic [CW-1:0] limit,
  input  logic          regs_empty,
  input  logic          mark_in,
  input  logic          drained,
  output logic [EW-1:0] out_ent [W],
  output logic [CW-1:0] taken,
  output logic [CW-1:0] used,
  output logic          ser_hit,
  output logic          res_hit,
  output logic [EW-1:0] held,
  output logic          mark_out
);
  import rn_pkg::*;

  always_comb begin
    automatic int  tk = 0;
    automatic int  us = 0;
    automatic logic stop = 1'b0;
    automatic logic mk = mark_in && !drained;
    ser_hit = 1'b0;
    res_hit = 1'b0;
    held    = '0;
    for (int i = 0; i < W; i++) out_ent[i] = '0;
    for (int i = 0; i < W; i++) begin
      if (!stop && i < int'(avail)) begin
        if (tk >= int'(limit)) begin
          stop = 1'b1; res_hit = 1'b1;
        end else if ((src[i][FL_SB] || mk) && !src[i][FL_HD]) begin
          stop = 1'b1; ser_hit = 1'b1;
          held = src[i] | EW'(1 << FL_HD);
          us++; mk = 1'b0;
        end else if (regs_empty) begin
          stop = 1'b1; res_hit = 1'b1;
        end else begin
          out_ent[tk] = src[i];
          tk++; us++;
          if (src[i][FL_SA] && !src[i][FL_HD]) mk = 1'b1;
        end
      end
    end
    taken    = CW'(tk);
    used     = CW'(us);
    mark_out = mk;
  end
endmodule

// File: rtl/rn_skid.sv
module rn_skid #(
  parameter int W     = 2,
  parameter int EW    = 11,
  parameter int DEPTH = 6,
  parameter int CW    = 2,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] pop_n,
  input  logic          front_en,
  input  logic [EW-1:0] front_e,
  input  logic [EW-1:0] app [W],
  input  logic [CW-1:0] app_off,
  input  logic [CW-1:0] app_n,
  output logic [EW-1:0] head [W],
  output logic [SW-1:0] cnt,
  output logic          ovf
);
  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] nxt [DEPTH];
  logic [SW-1:0] cnt_q;
  int            total;

  always_comb begin
    automatic int r  = int'(cnt_q) - int'(pop_n);
    automatic int kf = front_en ? 1 : 0;
    if (r < 0) r = 0;
    total = kf + r + int'(app_n);
    for (int j = 0; j < DEPTH; j++) begin
      automatic int k = j - kf;
      nxt[j] = '0;
      if (j < kf) nxt[j] = front_e;
      else if (k < r) begin
        if (k + int'(pop_n) < DEPTH) nxt[j] = mem[k + int'(pop_n)];
      end else if (k - r < int'(app_n) && int'(app_off) + k - r < W)
        nxt[j] = app[int'(app_off) + k - r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
    end else begin
      cnt_q <= clear ? '0 : (total > DEPTH ? SW'(DEPTH) : SW'(total));
      for (int j = 0; j < DEPTH; j++) mem[j] <= nxt[j];
    end
  end

  assign ovf = !clear && (total > DEPTH);
  assign cnt = cnt_q;
  always_comb for (int i = 0; i < W; i++) head[i] = mem[i];
endmodule

// File: rtl/rn_stage.sv
module rn_stage #(
  parameter int W        = 2,
  parameter int TAG_W    = 8,
  parameter int FB_DELAY = 1,
  parameter int CW       = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW-1:0]      dec_cnt,
  input  logic [W*TAG_W-1:0] dec_tags,
  input  logic [W-1:0]       dec_sb,
  input  logic [W-1:0]       dec_sa,
  input  logic [W-1:0]       dec_kill,
  input  logic [CW-1:0]      can_rename,
  input  logic               regs_empty,
  input  logic               rob_drained,
  input  logic               stall_in,
  input  logic               squash_in,
  input  logic               squashing_in,
  output logic [CW-1:0]      ren_cnt,
  output logic [W*TAG_W-1:0] ren_tags,
  output logic               blk_pulse,
  output logic               unblk_pulse,
  output logic [2:0]         state_o,
  output logic               skid_ovf
);
  import rn_pkg::*;

  localparam int EW    = TAG_W + FLAG_W;
  localparam int DEPTH = skid_cap(FB_DELAY, W);
  localparam int SW    = $clog2(DEPTH + 1);

  rn_state_e     state_q, state_d;
  logic          mark_q, mark_d;
  logic [EW-1:0] held_q, held_d;

  logic [EW-1:0] in_ent [W];
  logic [CW-1:0] in_n;
  logic [EW-1:0] sk_head [W];
  logic [SW-1:0] sk_cnt;
  logic          sk_ovf;
  logic [EW-1:0] src [W];
  logic [CW-1:0] avail, limit;
  logic [EW-1:0] sc_out [W];
  logic [CW-1:0] sc_taken, sc_used;
  logic          sc_ser, sc_res, sc_mark;
  logic [EW-1:0] sc_held;

  // control decisions brought out as named events
  logic          ev_clear, ev_front, ev_emit, ev_block, ev_unblock;
  logic [CW-1:0] pop_n, app_off, app_n;

  rn_compact #(.W(W), .TAG_W(TAG_W), .CW(CW), .EW(EW)) u_compact (
    .cnt(dec_cnt), .tags(dec_tags), .sb(dec_sb), .sa(dec_sa),
    .kill(dec_kill), .ent(in_ent), .n(in_n));

  always_comb begin
    for (int i = 0; i < W; i++)
      src[i] = (state_q == ST_UNBLOCK) ? sk_head[i] : in_ent[i];
    if (state_q == ST_UNBLOCK)
      avail = CW'(min_int(int'(sk_cnt), W));
    else
      avail = in_n;
    limit = CW'(min_int(int'(can_rename), W));
  end

  rn_scan #(.W(W), .CW(CW), .EW(EW)) u_scan (
    .src(src), .avail(avail), .limit(limit), .regs_empty(regs_empty),
    .mark_in(mark_q), .drained(rob_drained), .out_ent(sc_out),
    .taken(sc_taken), .used(sc_used), .ser_hit(sc_ser), .res_hit(sc_res),
    .held(sc_held), .mark_out(sc_mark));

  rn_skid #(.W(W), .EW(EW), .DEPTH(DEPTH), .CW(CW), .SW(SW)) u_skid (
    .clk(clk), .rst_n(rst_n), .clear(ev_clear), .pop_n(pop_n),
    .front_en(ev_front), .front_e(held_q), .app(in_ent), .app_off(app_off),
    .app_n(app_n), .head(sk_head), .cnt(sk_cnt), .ovf(sk_ovf));

  always_comb begin
    state_d    = state_q;
    mark_d     = mark_q;
    held_d     = held_q;
    ev_clear   = 1'b0;
    ev_front   = 1'b0;
    ev_emit    = 1'b0;
    ev_block   = 1'b0;
    ev_unblock = 1'b0;
    pop_n      = '0;
    app_off    = '0;
    app_n      = '0;
    if (squash_in) begin
      ev_clear   = 1'b1;
      ev_unblock = (state_q == ST_BLOCKED) || (state_q == ST_UNBLOCK) ||
                   (state_q == ST_SERIAL);
      mark_d     = 1'b0;
      held_d     = '0;
      state_d    = ST_SQUASH;
    end else begin
      unique case (state_q)
        ST_SQUASH: if (!squashing_in) state_d = ST_RUN;
        ST_BLOCKED: begin
          app_n = in_n;
          if (!stall_in) state_d = ST_UNBLOCK;
        end
        ST_SERIAL: begin
          app_n = in_n;
          if (rob_drained && !stall_in) begin
            ev_front = 1'b1;
            held_d   = '0;
            state_d  = ST_UNBLOCK;
          end
        end
        ST_UNBLOCK: begin
          app_n = in_n;
          if (stall_in) state_d = ST_BLOCKED;
          else begin
            ev_emit = 1'b1;
            pop_n   = sc_used;
            if (avail != '0) mark_d = sc_mark;
            if (sc_ser) begin
              held_d  = sc_held;
              state_d = ST_SERIAL;
            end else if (sc_res) state_d = ST_BLOCKED;
            else if (int'(sk_cnt) - int'(sc_used) + int'(in_n) == 0) begin
              ev_unblock = 1'b1;
              state_d    = ST_RUN;
            end
          end
        end
        default: begin
          if (stall_in) begin
            app_n    = in_n;
            ev_block = 1'b1;
            state_d  = ST_BLOCKED;
          end else if (in_n == '0) state_d = ST_IDLE;
          else begin
            ev_emit = 1'b1;
            mark_d  = sc_mark;
            app_off = sc_used;
            app_n   = in_n - sc_used;
            if (sc_ser) begin
              held_d   = sc_held;
              ev_block = 1'b1;
              state_d  = ST_SERIAL;
            end else if (sc_res) begin
              ev_block = 1'b1;
              state_d  = ST_BLOCKED;
            end else state_d = ST_RUN;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mark_q  <= 1'b0;
      held_q  <= '0;
    end else begin
      state_q <= state_d;
      mark_q  <= mark_d;
      held_q  <= held_d;
    end
  end

  generate
    for (genvar g = 0; g < W; g++) begin : g_out
      assign ren_tags[g*TAG_W +: TAG_W] = ev_emit ? sc_out[g][EW-1:FLAG_W] : '0;
    end
  endgenerate

  assign ren_cnt     = ev_emit ? sc_taken : '0;
  assign blk_pulse   = ev_block;
  assign unblk_pulse = ev_unblock;
  assign state_o     = state_q;
  assign skid_ovf    = sk_ovf;
endmodule

// File: rtl/rn_stage_chk.sv
module rn_stage_chk #(
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          squash_in,
  input logic          squashing_in,
  input logic [2:0]    state,
  input logic          blk,
  input logic          unblk,
  input logic          ovf,
  input logic [CW-1:0] ren_cnt,
  input logic [CW-1:0] can_rename
);
  import rn_pkg::*;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf);

  p_out_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ren_cnt <= can_rename);

  p_out_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_cnt != '0) |-> (state == ST_RUN || state == ST_IDLE || state == ST_UNBLOCK));

  p_block_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !(state == ST_BLOCKED || state == ST_UNBLOCK));

  p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk && unblk));

  p_unblock_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unblk && !squash_in) |=> state == ST_RUN);

  p_squash_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    squash_in |=> state == ST_SQUASH);

  p_squash_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH && squashing_in && !squash_in) |=> state == ST_SQUASH);

  p_squash_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SQUASH && !squashing_in && !squash_in) |=> state == ST_RUN);

  p_serial_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SERIAL && !squash_in) |=> (state == ST_SERIAL || state == ST_UNBLOCK));
endmodule

bind rn_stage rn_stage_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .squash_in(squash_in), .squashing_in(squashing_in),
  .state(state_o), .blk(ev_block), .unblk(ev_unblock), .ovf(sk_ovf),
  .ren_cnt(ren_cnt), .can_rename(can_rename));

// File: tb/test_rn_stage.sv
`timescale 1ns/1ps
module test_rn_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dec_cnt = '0;
  logic [15:0] dec_tags = '0;
  logic [1:0]  dec_sb = '0, dec_sa = '0, dec_kill = '0;
  logic [1:0]  can_rename = '0;
  logic        regs_empty = 1'b0, rob_drained = 1'b0, stall_in = 1'b0;
  logic        squash_in = 1'b0, squashing_in = 1'b0;
  logic [1:0]  ren_cnt;
  logic [15:0] ren_tags;
  logic        blk_pulse, unblk_pulse, skid_ovf;
  logic [2:0]  state_o;

  rn_stage i_rn_stage (.*);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0, cycles = 0;
  logic [7:0] exp_tag [1024];
  int wr = 0, rd = 0;
  logic [7:0] tag_ctr = 8'd0, first_tag;
  logic [1:0] s_cnt;
  logic [15:0] s_tags;
  logic s_blk, s_unblk, s_ovf;
  logic [2:0] s_state;
  bit dec_ok = 1'b1;

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      summary();
    end
  end

  // one cycle: drive at negedge, sample outputs 1 ns later, track tag order (R12)
  task automatic cyc(int n, logic [1:0] sbm, logic [1:0] sam, logic [1:0] km,
                     int can, bit regs, bit drn, bit stl, bit sq, bit sqing);
    @(negedge clk);
    first_tag = tag_ctr;
    dec_cnt = 2'(n); dec_sb = sbm; dec_sa = sam; dec_kill = km;
    for (int i = 0; i < 2; i++) begin
      dec_tags[i*8 +: 8] = tag_ctr + 8'(i);
      if (i < n && !km[i] && !sq && state_o != 3'd4) begin
        exp_tag[wr % 1024] = tag_ctr + 8'(i);
        wr++;
      end
    end
    tag_ctr = tag_ctr + 8'(n);
    can_rename = 2'(can); regs_empty = regs; rob_drained = drn;
    stall_in = stl; squash_in = sq; squashing_in = sqing;
    #1;
    s_cnt = ren_cnt; s_tags = ren_tags; s_blk = blk_pulse;
    s_unblk = unblk_pulse; s_state = state_o; s_ovf = skid_ovf;
    for (int i = 0; i < int'(s_cnt); i++) begin
      if (rd >= wr) check("R12 extra tag", int'(s_tags[i*8 +: 8]), -1);
      else begin
        check("R12 order", int'(s_tags[i*8 +: 8]), int'(exp_tag[rd % 1024]));
        rd++;
      end
    end
    if (sq) rd = wr;
    if (s_blk) dec_ok = 1'b0;
    if (s_unblk) dec_ok = 1'b1;
  endtask

  task automatic idle(int can = 2, bit drn = 1'b1);
    cyc(0, 2'b00, 2'b00, 2'b00, can, 1'b0, drn, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    logic [7:0] ta;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    idle();
    check("R1 state", s_state, 0); check("R1 cnt", s_cnt, 0);
    check("R1 blk", s_blk, 0); check("R1 unblk", s_unblk, 0);

    // R2 plain rename, two slots
    cyc(2, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 0, 0);
    check("R2 cnt", s_cnt, 2);
    check("R2 tag0", s_tags[7:0], first_tag);
    check("R2 tag1", s_tags[15:8], first_tag + 8'd1);
    idle(); check("R2 running", s_state, 1);
    // R2 killed slot uses no position
    cyc(2, 2'b00, 2'b00, 2'b01, 2, 0, 1, 0, 0, 0);
    check("R2 kill cnt", s_cnt, 1);
    check("R2 kill tag", s_tags[7:0], first_tag + 8'd1);

    // R4/R5/R6 limit block then drain
    cyc(2, 2'b00, 2'b00, 2'b00, 1, 0, 1, 0, 0, 0);
    check("R4 limit cnt", s_cnt, 1); check("R4 limit blk", s_blk, 1);
    idle(); check("R4 blocked", s_state, 2); check("R4 no out", s_cnt, 0);
    idle(); check("R5 unblocking", s_state, 3); check("R5 skid out", s_cnt, 1);
    check("R6 unblk", s_unblk, 1);
    idle(); check("R6 running", s_state, 1);

    // R4 stall_in block
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 1, 1, 0, 0);
    check("R4 stall blk", s_blk, 1); check("R4 stall cnt", s_cnt, 0);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 1, 1, 0, 0);
    check("R4 stall held", s_state, 2); check("R4 no reblk", s_blk, 0);
    idle(); check("R5 still blocked", s_state, 2);
    idle(); check("R5 unblock", s_state, 3); check("R6 stall unblk", s_unblk, 1);

    // R4 empty register pool
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 1, 1, 0, 0, 0);
    check("R4 regs cnt", s_cnt, 0); check("R4 regs blk", s_blk, 1);
    idle(); idle(); check("R6 regs drain", s_cnt, 1);

    // R9/R10 serialize-before
    cyc(1, 2'b01, 2'b00, 2'b00, 2, 0, 0, 0, 0, 0);
    ta = first_tag;
    check("R9 held cnt", s_cnt, 0); check("R9 blk", s_blk, 1);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 0, 1, 0, 0); check("R9 wait", s_state, 5);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 1, 1, 0, 0); check("R10 stall no block", s_state, 5);
    idle(); check("R10 still serial", s_state, 5);
    idle(); check("R9 unblocking", s_state, 3); check("R9 once", s_cnt, 1);
    check("R9 tag", s_tags[7:0], ta); check("R9 unblk", s_unblk, 1);

    // R11 serialize-after in same bundle
    cyc(2, 2'b00, 2'b01, 2'b00, 2, 0, 0, 0, 0, 0);
    check("R11 same cnt", s_cnt, 1); check("R11 same blk", s_blk, 1);
    idle(); idle(); check("R11 same drain", s_cnt, 1);
    // R11 sticky mark across cycles
    cyc(1, 2'b00, 2'b01, 2'b00, 2, 0, 0, 0, 0, 0); check("R11 sa out", s_cnt, 1);
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 0, 0, 0, 0);
    check("R11 sticky cnt", s_cnt, 0); check("R11 sticky blk", s_blk, 1);
    idle(); idle(); check("R11 sticky drain", s_cnt, 1);
    // R11 mark dropped when already drained
    cyc(1, 2'b00, 2'b01, 2'b00, 2, 0, 0, 0, 0, 0);
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 0, 0);
    check("R11 cleared cnt", s_cnt, 1); check("R11 cleared blk", s_blk, 0);

    // R7/R8 squash from Blocked
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 1, 1, 0, 0); check("R7 pre blk", s_blk, 1);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 1, 0); check("R7 unblk", s_unblk, 1);
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 0, 1);
    check("R8 squashing", s_state, 4); check("R8 ignored", s_cnt, 0);
    idle(); check("R8 hold", s_state, 4);
    idle(); check("R8 exit", s_state, 1);
    idle(); check("R8 nothing left", s_cnt, 0);
    // R7 squash from Running: no unblock
    cyc(1, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 0, 0);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 1, 0, 1, 0); check("R7 run no unblk", s_unblk, 0);
    idle(); check("R7 squash state", s_state, 4);
    // R7 squash drops held serializing instruction
    idle(); idle();
    cyc(1, 2'b01, 2'b00, 2'b00, 2, 0, 0, 0, 0, 0);
    cyc(0, 2'b00, 2'b00, 2'b00, 2, 0, 0, 0, 1, 0); check("R7 serial unblk", s_unblk, 1);
    idle(); idle(); idle(); check("R7 held dropped", s_cnt, 0);

    // R3/R12 random traffic
    dec_ok = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      automatic bit sq = ($urandom % 100) == 0;
      automatic int n = (dec_ok && !sq && state_o != 3'd4) ? int'($urandom % 3) : 0;
      automatic logic [1:0] sbm = '0, sam = '0, km = '0;
      automatic int can = int'($urandom % 4);
      for (int i = 0; i < 2; i++) begin
        automatic int r = int'($urandom % 16);
        sbm[i] = (r == 0); sam[i] = (r == 1); km[i] = (r == 2 || r == 3);
      end
      if (can > 2) can = 2;
      cyc(n, sbm, sam, km, can, ($urandom % 20) == 0, ($urandom % 3) == 0,
          ($urandom % 8) == 0, sq, ($urandom % 2) == 0);
      if (s_ovf) check("R3 overflow", 1, 0);
    end
    for (int c = 0; c < 30; c++) idle();
    check("R3 no overflow seen", s_ovf, 0);
    check("R12 all delivered", rd, wr);
    check("R6 settled", int'(s_state <= 3'd1), 1);
    summary();
  end

  initial void'($urandom(32'd1234));
endmodule